// File: doc/BRIEF.md
# Asymmetric Dual-Clock Parity RAM

This block is a true dual-port memory. Each port has its own clock, enable, write enable, address, write data, write parity, read data, read parity and a synchronous clear for its output register. The two ports share one storage array but can have different data widths. A narrow port can therefore write bytes that a wide port reads back as whole words, and the reverse also works.

Every byte lane stores one parity bit next to its data. The memory does not generate or check parity. It stores the bits it is given and returns them. A port narrower than eight bits has no parity and leaves the stored parity unchanged. The data capacity is a parameter, and the depth of each port is that capacity divided by the port's width. A parameter sets the data contents the memory holds when reset is released.

Top module: `asym_parity_ram`

## Requirements
- R1: An enabled access updates that port's read data register on the next rising edge of that port's clock, and only that port's clock. The read latency is one cycle.
- R2: Port depth is DATA_BITS divided by the port width. Address n on a port of width W covers stored data bits n*W to n*W+W-1. As a result, narrow address n falls in wide word n/ratio at lane n%ratio, and lane 0 is the least significant lane.
- R3: Parity bit k of a port of width 8 or more belongs to data byte k of that word. Parity written through one port is returned alongside the same bytes on the other port.
- R4: A write with the enable high returns the contents the location held before the write (read-first).
- R5: When the enable is low, neither the stored contents nor the port's read data and read parity change, whatever the write enable, address and data inputs are.
- R6: A port's synchronous clear sets its read data and read parity to zero on the next edge of that port's clock. A write requested in the same cycle is still performed.
- R7: While rst_ni is low, both outputs are zero. After rst_ni is released, the stored data equals INIT_DATA and all stored parity bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset; loads the initial contents |
| a_clk_i | input | 1 | Port A clock |
| a_en_i | input | 1 | Port A access enable |
| a_we_i | input | 1 | Port A write enable |
| a_srst_i | input | 1 | Port A synchronous output clear |
| a_addr_i | input | A_AW | Port A address |
| a_din_i | input | A_DW | Port A write data |
| a_pin_i | input | A_PWP | Port A write parity, one bit per byte |
| a_dout_o | output | A_DW | Port A read data |
| a_pout_o | output | A_PWP | Port A read parity |
| b_clk_i | input | 1 | Port B clock |
| b_en_i | input | 1 | Port B access enable |
| b_we_i | input | 1 | Port B write enable |
| b_srst_i | input | 1 | Port B synchronous output clear |
| b_addr_i | input | B_AW | Port B address |
| b_din_i | input | B_DW | Port B write data |
| b_pin_i | input | B_PWP | Port B write parity, one bit per byte |
| b_dout_o | output | B_DW | Port B read data |
| b_pout_o | output | B_PWP | Port B read parity |

## Verification
Every result appears on the first rising edge of the issuing port's own clock: read data, read-first old data, and clear-to-zero. Stored effects become visible one edge later, when the location is read again. The bench drives each operation on a falling edge of that port's clock and samples one time unit after the following rising edge. The two clocks have different periods, and only one port is active at a time, so no check depends on the relative phase of the clocks. Expected words are built in the bench from a byte-level model: four model bytes are concatenated with the lowest address in the least significant lane.

// File: rtl/aram_pkg.sv
package aram_pkg;
  function automatic int par_w(input int dw);
    return (dw >= 8) ? dw / 8 : 0;
  endfunction

  function automatic int par_w1(input int dw);
    return (dw >= 8) ? dw / 8 : 1;
  endfunction

  function automatic int aw_of(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/aram_port.sv
module aram_port
  import aram_pkg::*;
#(
  parameter int DW = 8,
  parameter int DATA_BITS = 512,
  parameter logic [DATA_BITS-1:0] OWN_INIT = '0,
  parameter int PAR_BITS = DATA_BITS / 8,
  parameter int AW = aw_of(DATA_BITS / DW),
  parameter int PWP = par_w1(DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 we_i,
  input  logic                 srst_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        din_i,
  input  logic [PWP-1:0]       pin_i,
  output logic [DW-1:0]        dout_o,
  output logic [PWP-1:0]       pout_o,
  input  logic [DATA_BITS-1:0] peer_data_i,
  input  logic [PAR_BITS-1:0]  peer_par_i,
  output logic [DATA_BITS-1:0] own_data_o,
  output logic [PAR_BITS-1:0]  own_par_o
);
  localparam int PW = par_w(DW);

  // Stored value = own ^ peer; each half has a single writer.
  logic [DATA_BITS-1:0] own_data_q;
  logic [DW-1:0]        cur_data;
  int                   dbase;

  assign dbase      = int'(addr_i) * DW;
  assign cur_data   = own_data_q[dbase +: DW] ^ peer_data_i[dbase +: DW];
  assign own_data_o = own_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_data_q <= OWN_INIT;
      dout_o     <= '0;
    end else begin
      if (srst_i)    dout_o <= '0;
      else if (en_i) dout_o <= cur_data;
      if (en_i && we_i)
        own_data_q[dbase +: DW] <= din_i ^ peer_data_i[dbase +: DW];
    end
  end

  generate
    if (PW > 0) begin : g_par
      logic [PAR_BITS-1:0] own_par_q;
      logic [PW-1:0]       cur_par;
      int                  pbase;

      assign pbase     = int'(addr_i) * PW;
      assign cur_par   = own_par_q[pbase +: PW] ^ peer_par_i[pbase +: PW];
      assign own_par_o = own_par_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          own_par_q <= '0;
          pout_o    <= '0;
        end else begin
          if (srst_i)    pout_o <= '0;
          else if (en_i) pout_o <= cur_par;
          if (en_i && we_i)
            own_par_q[pbase +: PW] <= pin_i ^ peer_par_i[pbase +: PW];
        end
      end
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{pin_i, peer_par_i};
      assign own_par_o  = '0;
      assign pout_o     = '0;
    end
  endgenerate
endmodule

// File: rtl/asym_parity_ram.sv
module asym_parity_ram
  import aram_pkg::*;
#(
  parameter int DATA_BITS = 512,
  parameter int A_DW = 8,
  parameter int B_DW = 32,
  parameter logic [DATA_BITS-1:0] INIT_DATA = '0,
  parameter int A_AW = aw_of(DATA_BITS / A_DW),
  parameter int B_AW = aw_of(DATA_BITS / B_DW),
  parameter int A_PWP = par_w1(A_DW),
  parameter int B_PWP = par_w1(B_DW)
) (
  input  logic             rst_ni,
  input  logic             a_clk_i,
  input  logic             a_en_i,
  input  logic             a_we_i,
  input  logic             a_srst_i,
  input  logic [A_AW-1:0]  a_addr_i,
  input  logic [A_DW-1:0]  a_din_i,
  input  logic [A_PWP-1:0] a_pin_i,
  output logic [A_DW-1:0]  a_dout_o,
  output logic [A_PWP-1:0] a_pout_o,
  input  logic             b_clk_i,
  input  logic             b_en_i,
  input  logic             b_we_i,
  input  logic             b_srst_i,
  input  logic [B_AW-1:0]  b_addr_i,
  input  logic [B_DW-1:0]  b_din_i,
  input  logic [B_PWP-1:0] b_pin_i,
  output logic [B_DW-1:0]  b_dout_o,
  output logic [B_PWP-1:0] b_pout_o
);
  localparam int PAR_BITS = DATA_BITS / 8;

  logic [DATA_BITS-1:0] a_data, b_data;
  logic [PAR_BITS-1:0]  a_par, b_par;

  aram_port #(
    .DW(A_DW), .DATA_BITS(DATA_BITS), .OWN_INIT(INIT_DATA),
    .PAR_BITS(PAR_BITS), .AW(A_AW), .PWP(A_PWP)
  ) u_pa (
    .clk_i(a_clk_i), .rst_ni(rst_ni), .en_i(a_en_i), .we_i(a_we_i),
    .srst_i(a_srst_i), .addr_i(a_addr_i), .din_i(a_din_i), .pin_i(a_pin_i),
    .dout_o(a_dout_o), .pout_o(a_pout_o),
    .peer_data_i(b_data), .peer_par_i(b_par),
    .own_data_o(a_data), .own_par_o(a_par)
  );

  aram_port #(
    .DW(B_DW), .DATA_BITS(DATA_BITS), .OWN_INIT('0),
    .PAR_BITS(PAR_BITS), .AW(B_AW), .PWP(B_PWP)
  ) u_pb (
    .clk_i(b_clk_i), .rst_ni(rst_ni), .en_i(b_en_i), .we_i(b_we_i),
    .srst_i(b_srst_i), .addr_i(b_addr_i), .din_i(b_din_i), .pin_i(b_pin_i),
    .dout_o(b_dout_o), .pout_o(b_pout_o),
    .peer_data_i(a_data), .peer_par_i(a_par),
    .own_data_o(b_data), .own_par_o(b_par)
  );
endmodule

// File: rtl/aram_chk.sv
module aram_chk #(
  parameter int A_DW = 8,
  parameter int B_DW = 32,
  parameter int A_PWP = 1,
  parameter int B_PWP = 4
) (
  input logic             rst_ni,
  input logic             a_clk_i,
  input logic             a_en_i,
  input logic             a_srst_i,
  input logic [A_DW-1:0]  a_dout_o,
  input logic [A_PWP-1:0] a_pout_o,
  input logic             b_clk_i,
  input logic             b_en_i,
  input logic             b_srst_i,
  input logic [B_DW-1:0]  b_dout_o,
  input logic [B_PWP-1:0] b_pout_o
);
  assert_a_clear_R6: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    a_srst_i |=> (a_dout_o == '0 && a_pout_o == '0));

  assert_b_clear_R6: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    b_srst_i |=> (b_dout_o == '0 && b_pout_o == '0));

  assert_a_hold_R5: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    (!a_en_i && !a_srst_i) |=> ($stable(a_dout_o) && $stable(a_pout_o)));

  assert_b_hold_R5: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    (!b_en_i && !b_srst_i) |=> ($stable(b_dout_o) && $stable(b_pout_o)));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_out_R7: assert (a_dout_o == '0 && b_dout_o == '0
                                   && a_pout_o == '0 && b_pout_o == '0);
    end
  end
endmodule

bind asym_parity_ram aram_chk #(
  .A_DW(A_DW), .B_DW(B_DW), .A_PWP(A_PWP), .B_PWP(B_PWP)
) u_chk (
  .rst_ni(rst_ni),
  .a_clk_i(a_clk_i), .a_en_i(a_en_i), .a_srst_i(a_srst_i),
  .a_dout_o(a_dout_o), .a_pout_o(a_pout_o),
  .b_clk_i(b_clk_i), .b_en_i(b_en_i), .b_srst_i(b_srst_i),
  .b_dout_o(b_dout_o), .b_pout_o(b_pout_o)
);

// File: tb/sim_asym_parity_ram.sv
module sim_asym_parity_ram;
  localparam int DB = 512;
  localparam int NB = DB / 8;   // bytes
  localparam int NW = DB / 32;  // words

  function automatic logic [DB-1:0] mk_init();
    logic [DB-1:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = 8'((i * 5 + 1) & 255);
    return v;
  endfunction
  localparam logic [DB-1:0] INIT = mk_init();

  logic rst_ni = 1'b0;
  logic a_clk = 1'b0, b_clk = 1'b0;
  logic a_en = 0, a_we = 0, a_srst = 0;
  logic [5:0] a_addr = '0;
  logic [7:0] a_din = '0;
  logic [0:0] a_pin = '0;
  logic [7:0] a_dout;
  logic [0:0] a_pout;
  logic b_en = 0, b_we = 0, b_srst = 0;
  logic [3:0] b_addr = '0;
  logic [31:0] b_din = '0;
  logic [3:0] b_pin = '0;
  logic [31:0] b_dout;
  logic [3:0] b_pout;

  always #10 a_clk = ~a_clk;  // 50 MHz
  always #15 b_clk = ~b_clk;

  asym_parity_ram #(.DATA_BITS(DB), .A_DW(8), .B_DW(32), .INIT_DATA(INIT)) u0 (
    .rst_ni(rst_ni),
    .a_clk_i(a_clk), .a_en_i(a_en), .a_we_i(a_we), .a_srst_i(a_srst),
    .a_addr_i(a_addr), .a_din_i(a_din), .a_pin_i(a_pin),
    .a_dout_o(a_dout), .a_pout_o(a_pout),
    .b_clk_i(b_clk), .b_en_i(b_en), .b_we_i(b_we), .b_srst_i(b_srst),
    .b_addr_i(b_addr), .b_din_i(b_din), .b_pin_i(b_pin),
    .b_dout_o(b_dout), .b_pout_o(b_pout)
  );

  logic [7:0] m_dat[NB];
  logic       m_par[NB];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int w);
    return {m_dat[4*w+3], m_dat[4*w+2], m_dat[4*w+1], m_dat[4*w]};
  endfunction
  function automatic logic [3:0] exp_wpar(input int w);
    return {m_par[4*w+3], m_par[4*w+2], m_par[4*w+1], m_par[4*w]};
  endfunction

  task automatic a_op(input logic en, input logic we, input logic srst,
                      input int addr, input logic [7:0] d, input logic p);
    @(negedge a_clk);
    a_en = en; a_we = we; a_srst = srst; a_addr = 6'(addr); a_din = d; a_pin = p;
    @(posedge a_clk); #1;
    a_en = 0; a_we = 0; a_srst = 0;
  endtask

  task automatic b_op(input logic en, input logic we, input logic srst,
                      input int addr, input logic [31:0] d, input logic [3:0] p);
    @(negedge b_clk);
    b_en = en; b_we = we; b_srst = srst; b_addr = 4'(addr); b_din = d; b_pin = p;
    @(posedge b_clk); #1;
    b_en = 0; b_we = 0; b_srst = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_dat[i] = INIT[i*8 +: 8]; m_par[i] = 1'b0; end
    #45;
    check("R7 reset a_dout", 64'(a_dout), 64'h0);
    check("R7 reset b_dout", 64'(b_dout), 64'h0);
    check("R7 reset parity", 64'({a_pout, b_pout}), 64'h0);
    rst_ni = 1'b1;

    // R7/R2: initial contents seen as words and as bytes
    for (int w = 0; w < NW; w++) begin
      b_op(1, 0, 0, w, '0, '0);
      check("R7 R2 init word", 64'(b_dout), 64'(exp_word(w)));
      check("R7 init parity", 64'(b_pout), 64'h0);
    end
    for (int i = 0; i < NB; i++) begin
      a_op(1, 0, 0, i, '0, 0);
      check("R1 R7 init byte", 64'(a_dout), 64'(m_dat[i]));
    end

    // R4: byte writes with read-first, then word readback R2/R3
    for (int i = 0; i < NB; i++) begin
      logic [7:0] nd = 8'(((i * 29 + 7) & 255) ^ 8'h5A);
      logic np = 1'(i) ^ 1'(i >> 3);
      a_op(1, 1, 0, i, nd, np);
      check("R4 A read-first", 64'(a_dout), 64'(m_dat[i]));
      check("R4 A read-first parity", 64'(a_pout), 64'(m_par[i]));
      m_dat[i] = nd; m_par[i] = np;
    end
    for (int w = 0; w < NW; w++) begin
      b_op(1, 0, 0, w, '0, '0);
      check("R2 bytes as word", 64'(b_dout), 64'(exp_word(w)));
      check("R3 parity lanes", 64'(b_pout), 64'(exp_wpar(w)));
    end

    // Word writes via B (read-first), byte readback via A
    for (int w = 0; w < NW; w++) begin
      logic [31:0] nw = 32'h9E37_79B9 * 32'(w + 1);
      logic [3:0] np = 4'(w) ^ 4'hA;
      b_op(1, 1, 0, w, nw, np);
      check("R4 B read-first", 64'(b_dout), 64'(exp_word(w)));
      check("R4 B read-first parity", 64'(b_pout), 64'(exp_wpar(w)));
      for (int k = 0; k < 4; k++) begin m_dat[4*w+k] = nw[k*8 +: 8]; m_par[4*w+k] = np[k]; end
    end
    for (int i = 0; i < NB; i++) begin
      a_op(1, 0, 0, i, '0, 0);
      check("R2 word as bytes", 64'(a_dout), 64'(m_dat[i]));
      check("R3 byte parity", 64'(a_pout), 64'(m_par[i]));
    end

    // R5: enable low blocks write and holds the output
    a_op(1, 0, 0, 9, '0, 0);
    a_op(0, 1, 0, 5, 8'hFF, 1);
    check("R5 A output held", 64'(a_dout), 64'(m_dat[9]));
    a_op(1, 0, 0, 5, '0, 0);
    check("R5 A no write", 64'(a_dout), 64'(m_dat[5]));
    check("R5 A no parity write", 64'(a_pout), 64'(m_par[5]));
    b_op(1, 0, 0, 3, '0, '0);
    b_op(0, 1, 0, 7, 32'hFFFF_FFFF, 4'hF);
    check("R5 B output held", 64'(b_dout), 64'(exp_word(3)));
    b_op(1, 0, 0, 7, '0, '0);
    check("R5 B no write", 64'(b_dout), 64'(exp_word(7)));

    // R6: clear with a concurrent write; write must still land
    a_op(1, 1, 1, 12, 8'hC4, 1);
    check("R6 A clear data", 64'(a_dout), 64'h0);
    check("R6 A clear parity", 64'(a_pout), 64'h0);
    m_dat[12] = 8'hC4; m_par[12] = 1'b1;
    b_op(1, 0, 0, 3, '0, '0);
    check("R6 write kept", 64'(b_dout), 64'(exp_word(3)));
    check("R6 write kept parity", 64'(b_pout), 64'(exp_wpar(3)));
    b_op(0, 0, 1, 0, '0, '0);
    check("R6 B clear data", 64'(b_dout), 64'h0);
    check("R6 B clear parity", 64'(b_pout), 64'h0);

    // R1: A access leaves B output alone and vice versa
    b_op(1, 0, 0, 1, '0, '0);
    a_op(1, 0, 0, 0, '0, 0);
    check("R1 B unaffected by A", 64'(b_dout), 64'(exp_word(1)));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule